// File: doc/BRIEF.md
# Segmented Logical-to-Linear Address Translator

This block turns a segment:offset pair into a linear address. It has two modes, chosen for each request by the `prot_mode` input.

In real mode, the 16-bit segment value is moved up by one hex digit and added to a 16-bit offset. The sum is kept to 20 bits and zero-extended to 32 bits.

In protected mode, the selector picks a descriptor from one of two internal tables: global or local. The descriptor supplies a 32-bit base, which is added to the 32-bit offset. It also supplies a 20-bit limit, counted either in bytes or in 4 KB units. An offset beyond that limit, or a selector that points past the end of a table, produces a fault instead of an address.

Descriptors are loaded through a one-cycle write port. Each request is a one-cycle strobe. The answer appears on the registered outputs one clock later.

Top module: `seg_xlate`

## Requirements
- R1: In real mode, the linear address is `sel*16 + ofs[15:0]`. Offset bits [31:16] have no effect. For example, A1F0:04C0 gives 0x000A23C0.
- R2: In real mode, the sum is truncated to 20 bits and bits [31:20] of `lin_addr` are zero. For example, FFFF:FFFF gives 0x0000FFEF.
- R3: A real-mode request never faults. It always answers with `valid`=1.
- R4: In protected mode, the table index is `sel[15:3]`. `sel[2]` chooses the table: 0 selects global, 1 selects local. `sel[1:0]` has no effect.
- R5: For a protected request that does not fault, `lin_addr` = descriptor base + `ofs`, modulo 2^32.
- R6: With the granularity bit clear, a protected request faults exactly when `ofs` > limit.
- R7: With the granularity bit set, the effective limit is `{limit, 12'hFFF}`. A protected request faults exactly when `ofs` exceeds that value.
- R8: A protected request whose index is greater than or equal to `DEPTH` faults.
- R9: `valid` or `fault` is high, exactly one of them, in the cycle after a request, and only then. When `fault` is high, `lin_addr` is 0.
- R10: A write with `wr_en` high stores base, limit and granularity into entry `wr_idx` of the table chosen by `wr_tbl` (0 = global, 1 = local). It affects requests from the next cycle onward and leaves the other table untouched.
- R11: Reset clears `valid`, `fault` and `lin_addr`. It also clears every descriptor to base 0, limit 0, byte granularity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Translation request strobe |
| prot_mode | input | 1 | 1 = protected mode, 0 = real mode |
| sel | input | 16 | Segment value (real mode) or selector (protected mode) |
| ofs | input | 32 | Offset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_tbl | input | 1 | Table to write: 0 = global, 1 = local |
| wr_idx | input | IW | Entry to write |
| wr_base | input | 32 | Base address to store |
| wr_limit | input | 20 | Limit to store |
| wr_gran | input | 1 | 1 = limit counts 4 KB units |
| lin_addr | output | 32 | Linear address |
| valid | output | 1 | Translation succeeded |
| fault | output | 1 | Limit or index fault |

## Verification
The hardest cases to reach are the exact limit boundaries. Each one needs a descriptor whose limit is known, followed by an offset one above or equal to the effective limit, in both granularities. The bench writes computed descriptors into every entry of both tables. It then probes each entry at offset zero, at the effective limit and one past it, using a varying `sel[1:0]`.

Before any write, a probe of the reset descriptor shows the cleared limit at the ports. Two further cases are driven directly: indexes just past the table, and real-mode carries out of bit 19.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int DEPTH = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          prot_mode,
  input  logic [15:0]   sel,
  input  logic [31:0]   ofs,
  input  logic          wr_en,
  input  logic          wr_tbl,
  input  logic [IW-1:0] wr_idx,
  input  logic [31:0]   wr_base,
  input  logic [19:0]   wr_limit,
  input  logic          wr_gran,
  output logic [31:0]   lin_addr,
  output logic          valid,
  output logic          fault
);
  localparam logic [13:0] DEPTH_W = 14'(DEPTH);

  logic [31:0] base_q [2][DEPTH];
  logic [19:0] lim_q  [2][DEPTH];
  logic        gran_q [2][DEPTH];

  logic [12:0]   idx;
  logic          ti;
  logic          in_range;
  logic [IW-1:0] ridx;
  logic [31:0]   d_base;
  logic [19:0]   d_lim;
  logic          d_gran;
  logic [31:0]   eff_lim;
  logic [19:0]   real_sum;
  logic          p_fault;
  logic          unused_rpl;

  assign idx        = sel[15:3];
  assign ti         = sel[2];
  assign unused_rpl = ^sel[1:0];
  assign in_range   = {1'b0, idx} < DEPTH_W;
  assign ridx       = idx[IW-1:0];
  assign d_base     = base_q[ti][ridx];
  assign d_lim      = lim_q[ti][ridx];
  assign d_gran     = gran_q[ti][ridx];
  assign eff_lim    = d_gran ? {d_lim, 12'hFFF} : {12'h000, d_lim};
  assign p_fault    = !in_range || (ofs > eff_lim);
  assign real_sum   = {sel, 4'h0} + {4'h0, ofs[15:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++)
        for (int e = 0; e < DEPTH; e++) begin
          base_q[t][e] <= '0;
          lim_q[t][e]  <= '0;
          gran_q[t][e] <= 1'b0;
        end
    end else if (wr_en) begin
      base_q[wr_tbl][wr_idx] <= wr_base;
      lim_q[wr_tbl][wr_idx]  <= wr_limit;
      gran_q[wr_tbl][wr_idx] <= wr_gran;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      fault    <= 1'b0;
      lin_addr <= '0;
    end else begin
      valid <= 1'b0;
      fault <= 1'b0;
      if (req) begin
        if (!prot_mode) begin
          valid    <= 1'b1;
          lin_addr <= {12'h000, real_sum};
        end else if (p_fault) begin
          fault    <= 1'b1;
          lin_addr <= '0;
        end else begin
          valid    <= 1'b1;
          lin_addr <= d_base + ofs;
        end
      end
    end
  end

  p_one_hot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && fault));
  p_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (valid || fault));
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid || fault) |-> $past(req));
  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (lin_addr == 32'h0));
  p_real_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !prot_mode) |=> (valid && !fault));
  p_real_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !prot_mode) |=> (lin_addr[31:20] == 12'h000));
  p_bad_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && prot_mode && ({1'b0, sel[15:3]} >= DEPTH_W)) |=> fault);
endmodule

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;
  localparam int DEPTH = 16;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, prot_mode = 1'b0;
  logic [15:0] sel = '0;
  logic [31:0] ofs = '0;
  logic wr_en = 1'b0, wr_tbl = 1'b0, wr_gran = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_base = '0;
  logic [19:0] wr_limit = '0;
  logic [31:0] lin_addr;
  logic valid, fault;

  int errors = 0;
  int checks = 0;

  logic [31:0] m_base [2][DEPTH];
  logic [19:0] m_lim  [2][DEPTH];
  logic        m_gran [2][DEPTH];

  always #4 clk = ~clk;

  seg_xlate #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .prot_mode(prot_mode), .sel(sel), .ofs(ofs),
    .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_idx(wr_idx), .wr_base(wr_base),
    .wr_limit(wr_limit), .wr_gran(wr_gran),
    .lin_addr(lin_addr), .valid(valid), .fault(fault));

  task automatic chk(input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic pm, input logic [15:0] s, input logic [31:0] o,
                       input logic exp_f, input logic [31:0] exp_a, input string tag);
    @(negedge clk);
    req = 1'b1; prot_mode = pm; sel = s; ofs = o;
    @(negedge clk);
    req = 1'b0;
    chk(tag, {valid, fault, lin_addr}, {!exp_f, exp_f, exp_f ? 32'h0 : exp_a});
    @(negedge clk);
    chk("R9 idle", {valid, fault}, 34'h0);
  endtask

  task automatic wdesc(input logic t, input int e, input logic [31:0] b,
                       input logic [19:0] l, input logic g);
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = t; wr_idx = IW'(e); wr_base = b; wr_limit = l; wr_gran = g;
    @(negedge clk);
    wr_en = 1'b0;
    m_base[t][e] = b; m_lim[t][e] = l; m_gran[t][e] = g;
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {valid, fault, lin_addr}, 34'h0);
    rst_n = 1'b1;

    // R11: reset descriptors have base 0, byte limit 0
    xlate(1'b1, 16'h0000, 32'h0, 1'b0, 32'h0, "R11 reset desc in limit");
    xlate(1'b1, 16'h0004, 32'h1, 1'b1, 32'h0, "R11 reset desc limit 0");

    // R1/R2/R3 real mode
    xlate(1'b0, 16'hA1F0, 32'h0000_04C0, 1'b0, 32'h000A23C0, "R1 example");
    xlate(1'b0, 16'h028F, 32'hABCD_0030, 1'b0, 32'h00002920, "R1 upper ofs ignored");
    xlate(1'b0, 16'hFFFF, 32'h0000_FFFF, 1'b0, 32'h0000FFEF, "R2 wrap");
    for (int i = 0; i < 64; i++) begin
      logic [15:0] s;
      logic [31:0] o;
      logic [19:0] e;
      s = 16'(i * 16'h0409 + 16'hF000 * (i % 2));
      o = {16'(i * 16'h1357), 16'(16'hFFFF - i * 16'h0A11)};
      e = {s, 4'h0} + {4'h0, o[15:0]};
      xlate(1'b0, s, o, 1'b0, {12'h0, e}, "R1 R2 R3 real sweep");
    end

    // R10: load both tables with distinct values
    for (int t = 0; t < 2; t++)
      for (int e = 0; e < DEPTH; e++)
        wdesc(t[0], e, 32'(e * 32'h0123_4567) ^ (t == 1 ? 32'hF000_0000 : 32'h0),
              20'(e * 20'h0A5A3 + t * 20'h00017), e[0] ^ t[0]);
    wdesc(1'b1, 3, 32'hFFFF_F000, 20'hFFFFF, 1'b1);

    // R4 R5 R6 R7 protected sweep
    for (int t = 0; t < 2; t++)
      for (int e = 0; e < DEPTH; e++) begin
        logic [31:0] eff;
        logic [15:0] s;
        eff = m_gran[t][e] ? {m_lim[t][e], 12'hFFF} : {12'h0, m_lim[t][e]};
        s = {13'(e), t[0], 2'(e + t)};
        xlate(1'b1, s, 32'h0, 1'b0, m_base[t][e], "R4 R5 ofs zero");
        xlate(1'b1, s, eff, 1'b0, m_base[t][e] + eff,
              m_gran[t][e] ? "R7 at limit" : "R6 at limit");
        if (eff != 32'hFFFF_FFFF)
          xlate(1'b1, s, eff + 1, 1'b1, 32'h0,
                m_gran[t][e] ? "R7 past limit" : "R6 past limit");
      end

    // R8 index out of range
    xlate(1'b1, {13'(DEPTH), 3'b000}, 32'h0, 1'b1, 32'h0, "R8 index=DEPTH");
    xlate(1'b1, 16'hFFFF, 32'h0, 1'b1, 32'h0, "R8 max index");

    // R10: write to local does not touch global
    wdesc(1'b1, 0, 32'h1234_0000, 20'h00010, 1'b0);
    xlate(1'b1, 16'h0000, 32'h0, 1'b0, m_base[0][0], "R10 global untouched");
    xlate(1'b1, 16'h0004, 32'h10, 1'b0, 32'h1234_0010, "R10 local updated");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule